// File: doc/BRIEF.md
# Masked Time-of-Day Alarm with Interrupt

This block watches a running calendar time (seconds, minutes, hours and day of month, all in BCD) and raises an alarm when that time agrees with a programmed alarm time. Each of the four alarm registers holds a BCD value in its lower bits and a "don't care" mask bit in bit 7. The four mask bits together pick how often the alarm repeats: every second, or whenever seconds, minutes and seconds, hours through seconds, or date through seconds agree. The comparison is made once for each 1 Hz tick, so each qualifying second sets the alarm flag exactly once.

A set alarm flag pulls the active-low interrupt output low when the alarm enable bit is set. While the system runs from its backup supply, a second enable bit must also be set before the interrupt can assert, so the alarm can serve as a wakeup. Any read or write of the flags register releases the interrupt at once, and the flag itself clears when that access ends. Register accesses are ignored while in backup mode. When main power returns, both enable bits are cleared, but an alarm that lands in that cycle still sets the flag.

Software reaches the block through a simple strobe bus: a one-cycle strobe with an address, a write indication and write data, with read data returned in the same cycle.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset, irq_n is 1 and every register (addresses 0 to 5) reads 0.
- R2: Addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (date) read back all 8 written bits; address 4 (control) reads back bit 0 as the alarm enable and bit 1 as the backup enable, other bits 0; address 5 (flags) reads the alarm flag in bit 6 with all other bits 0; other addresses read 0.
- R3: With masks {date,hours,minutes,seconds} bit 7 = 1111, or any combination other than 1110, 1100, 1000 and 0000, every tick sets the alarm flag.
- R4: With masks 1110, a tick sets the flag only when seconds bits [6:0] equal the alarm seconds bits [6:0].
- R5: With masks 1100, a tick sets the flag only when seconds and minutes (bits [6:0]) both agree.
- R6: With masks 1000, a tick sets the flag only when seconds, minutes and hours (hours bits [5:0]) all agree.
- R7: With masks 0000, a tick sets the flag only when seconds, minutes, hours and date (date bits [5:0]) all agree.
- R8: The flag is never set in a cycle without a tick; the flag set by a tick in cycle N is visible from cycle N+1.
- R9: Outside backup mode, irq_n is 0 exactly when the flag is 1 and the alarm enable is 1, except during a flags access.
- R10: During the strobe cycle of a flags read or write, irq_n is 1 and the read returns the flag still set; from the next cycle the flag is 0.
- R11: A qualifying tick in the same cycle as a flags access leaves the flag set.
- R12: In backup mode, irq_n is 0 only when the flag, the alarm enable and the backup enable are all 1.
- R13: When backup mode ends, both enable bits clear to 0; a qualifying tick in that cycle still sets the flag.
- R14: While backup mode is active, bus writes change no register and flags accesses do not clear the flag or release irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse each second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| backup | input | 1 | High while running from backup supply |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the strobe |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The repeat-rate decode is tried with random alarm values and random mask combinations, where each current-time field is either copied from the alarm or drawn at random, so that every mode sees both near-misses in a single field and full agreement; this separates which fields each mode compares. Undefined mask combinations are driven with deliberately disagreeing time to tell them apart from the matching modes. Directed sequences cover a tick colliding with a flags access, accesses and interrupt gating in backup mode, and an alarm landing in the cycle power returns.

// File: rtl/alarm_match_irq.sv
module alarm_match_irq #(
  parameter logic [2:0] A_SEC  = 3'd0,
  parameter logic [2:0] A_MIN  = 3'd1,
  parameter logic [2:0] A_HOUR = 3'd2,
  parameter logic [2:0] A_DATE = 3'd3,
  parameter logic [2:0] A_CTRL = 3'd4,
  parameter logic [2:0] A_FLAG = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_date,
  input  logic       backup,
  input  logic       bus_stb,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_n
);

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       ae, abe, af, bk_q;
  logic       hit_sel;

  wire acc      = bus_stb & ~backup;
  wire wr       = acc & bus_we;
  wire flag_hit = acc & (bus_addr == A_FLAG);
  wire pwr_up   = bk_q & ~backup;

  wire [3:0] mask = {al_date[7], al_hour[7], al_min[7], al_sec[7]};
  wire sec_eq  = al_sec[6:0]  == cur_sec[6:0];
  wire min_eq  = al_min[6:0]  == cur_min[6:0];
  wire hour_eq = al_hour[5:0] == cur_hour[5:0];
  wire date_eq = al_date[5:0] == cur_date[5:0];

  always_comb begin
    case (mask)
      4'b1110: hit_sel = sec_eq;
      4'b1100: hit_sel = sec_eq & min_eq;
      4'b1000: hit_sel = sec_eq & min_eq & hour_eq;
      4'b0000: hit_sel = sec_eq & min_eq & hour_eq & date_eq;
      default: hit_sel = 1'b1;
    endcase
  end

  wire fire = tick & hit_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_date <= '0;
      ae      <= 1'b0;
      abe     <= 1'b0;
      af      <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      bk_q <= backup;
      if (wr && bus_addr == A_SEC)  al_sec  <= bus_wdata;
      if (wr && bus_addr == A_MIN)  al_min  <= bus_wdata;
      if (wr && bus_addr == A_HOUR) al_hour <= bus_wdata;
      if (wr && bus_addr == A_DATE) al_date <= bus_wdata;
      if (pwr_up) begin
        ae  <= 1'b0;
        abe <= 1'b0;
      end else if (wr && bus_addr == A_CTRL) begin
        ae  <= bus_wdata[0];
        abe <= bus_wdata[1];
      end
      if (fire)          af <= 1'b1;
      else if (flag_hit) af <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc) begin
      case (bus_addr)
        A_SEC:   bus_rdata = al_sec;
        A_MIN:   bus_rdata = al_min;
        A_HOUR:  bus_rdata = al_hour;
        A_DATE:  bus_rdata = al_date;
        A_CTRL:  bus_rdata = {6'b0, abe, ae};
        A_FLAG:  bus_rdata = {1'b0, af, 6'b0};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_n = ~(af & ae & (abe | ~backup) & ~flag_hit);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (af && ae));

  // R8
  af_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(tick));

  // R10
  af_clear_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !backup && bus_addr == A_FLAG && !tick) |=> !af);

  // R11
  af_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit_sel) |=> af);

  // R12
  backup_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (backup && !irq_n) |-> (abe && ae));

  // R13
  pwrup_enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(backup) |=> (!ae && !abe));

  // R14
  backup_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backup |=> ($stable(al_sec) && $stable(al_min) && $stable(al_hour) &&
                $stable(al_date) && $stable(ae) && $stable(abe)));

endmodule

// File: tb/tb_alarm_match_irq.sv
module tb_alarm_match_irq;
  logic clk = 0, rst_n = 0, tick = 0, backup = 0;
  logic bus_stb = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0;
  logic [7:0] bus_rdata;
  logic irq_n;
  int checks = 0, failures = 0;
  logic acc_irq;

  always #2 clk = ~clk;

  alarm_match_irq dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date), .backup(backup),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_stb = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_stb = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; acc_irq = irq_n;
    @(negedge clk);
    bus_stb = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
  endtask

  task automatic pulse_tick;
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    #1;
  endtask

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic bit exp_fire(input logic [7:0] a0, a1, a2, a3, s, m, h, d);
    bit se = a0[6:0] == s[6:0];
    bit me = a1[6:0] == m[6:0];
    bit he = a2[5:0] == h[5:0];
    bit de = a3[5:0] == d[5:0];
    logic [3:0] mk = {a3[7], a2[7], a1[7], a0[7]};
    if (mk == 4'b1110) return se;
    if (mk == 4'b1100) return se & me;
    if (mk == 4'b1000) return se & me & he;
    if (mk == 4'b0000) return se & me & he & de;
    return 1'b1;
  endfunction

  function automatic string req_of(input logic [3:0] mk);
    if (mk == 4'b1110) return "R4";
    if (mk == 4'b1100) return "R5";
    if (mk == 4'b1000) return "R6";
    if (mk == 4'b0000) return "R7";
    return "R3";
  endfunction

  initial begin
    #(4 * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] a[4];
    logic [7:0] t[4];
    bit e;
    void'($urandom(32'd7741));
    #9 rst_n = 1;

    // R1 reset state
    #1 chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      chk(d === 8'h00, "R1 reset read", d, 0);
    end

    // R2 readback
    wr(3'd0, 8'hA5); rd(3'd0, d); chk(d === 8'hA5, "R2 sec", d, 8'hA5);
    wr(3'd3, 8'h5A); rd(3'd3, d); chk(d === 8'h5A, "R2 date", d, 8'h5A);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk(d === 8'h03, "R2 ctrl", d, 8'h03);
    rd(3'd6, d); chk(d === 8'h00, "R2 unused", d, 0);

    // R3 undefined mask fires with nothing agreeing; R8 no tick no flag
    wr(3'd0, 8'h80 | bcd(10)); wr(3'd1, bcd(20)); wr(3'd2, 8'h80 | bcd(5)); wr(3'd3, bcd(9));
    wr(3'd4, 8'h00);
    set_time(bcd(33), bcd(44), bcd(11), bcd(22));
    repeat (5) @(negedge clk);
    rd(3'd5, d); chk(d === 8'h00, "R8 no tick", d, 0);
    pulse_tick;
    chk(irq_n === 1'b1, "R9 irq masked by enable", irq_n, 1);
    rd(3'd5, d); chk(d === 8'h40, "R3 undefined mask", d, 8'h40);

    // R9 / R10 interrupt and release
    wr(3'd4, 8'h01);
    pulse_tick;
    chk(irq_n === 1'b0, "R9 irq asserted", irq_n, 0);
    rd(3'd5, d);
    chk(acc_irq === 1'b1, "R10 irq released in access", acc_irq, 1);
    chk(d === 8'h40, "R10 flag seen in access", d, 8'h40);
    #1 chk(irq_n === 1'b1, "R10 irq stays released", irq_n, 1);
    rd(3'd5, d); chk(d === 8'h00, "R10 flag cleared", d, 0);
    pulse_tick;
    wr(3'd5, 8'hFF);
    rd(3'd5, d); chk(d === 8'h00, "R10 write clears", d, 0);

    // R11 tick during flags access
    @(negedge clk);
    tick = 1; bus_stb = 1; bus_we = 0; bus_addr = 3'd5;
    @(negedge clk);
    tick = 0; bus_stb = 0;
    rd(3'd5, d); chk(d === 8'h40, "R11 set wins", d, 8'h40);

    // R12 backup gating
    wr(3'd4, 8'h01); pulse_tick;
    @(negedge clk); backup = 1; #1;
    chk(irq_n === 1'b1, "R12 no backup enable", irq_n, 1);
    @(negedge clk); backup = 0;
    @(negedge clk);
    wr(3'd4, 8'h03); pulse_tick;
    @(negedge clk); backup = 1; #1;
    chk(irq_n === 1'b0, "R12 both enables", irq_n, 0);

    // R14 accesses ignored in backup
    wr(3'd0, 8'h11); wr(3'd4, 8'h00);
    rd(3'd5, d);
    #1 chk(irq_n === 1'b0, "R14 flags access ignored", irq_n, 0);

    // R13 power return with alarm in same cycle
    @(negedge clk);
    backup = 0; tick = 1;
    @(negedge clk);
    tick = 0;
    rd(3'd4, d); chk(d === 8'h00, "R13 enables cleared", d, 0);
    rd(3'd0, d); chk(d === (8'h80 | bcd(10)), "R14 reg unchanged", d, 8'h80 | bcd(10));
    rd(3'd5, d); chk(d === 8'h40, "R13 flag kept", d, 8'h40);

    // Random mask/time trials for R3..R7, R9
    for (int it = 0; it < 400; it++) begin
      logic [3:0] mk;
      bit en;
      logic [3:0] pick;
      pick = 4'($urandom % 8);
      case (pick)
        0, 1: mk = 4'b1110;
        2: mk = 4'b1100;
        3: mk = 4'b1000;
        4, 5: mk = 4'b0000;
        6: mk = 4'b1111;
        default: mk = 4'($urandom);
      endcase
      a[0] = {mk[0], bcd($urandom % 60)[6:0]};
      a[1] = {mk[1], bcd($urandom % 60)[6:0]};
      a[2] = {mk[2], 1'b0, bcd($urandom % 24)[5:0]};
      a[3] = {mk[3], 1'b0, bcd(1 + $urandom % 31)[5:0]};
      t[0] = ($urandom % 3 != 0) ? {1'b0, a[0][6:0]} : bcd($urandom % 60);
      t[1] = ($urandom % 3 != 0) ? {1'b0, a[1][6:0]} : bcd($urandom % 60);
      t[2] = ($urandom % 3 != 0) ? {2'b0, a[2][5:0]} : bcd($urandom % 24);
      t[3] = ($urandom % 3 != 0) ? {2'b0, a[3][5:0]} : bcd(1 + $urandom % 31);
      en = 1'($urandom);
      for (int k = 0; k < 4; k++) wr(3'(k), a[k]);
      wr(3'd4, {7'b0, en});
      rd(3'd5, d);
      set_time(t[0], t[1], t[2], t[3]);
      pulse_tick;
      e = exp_fire(a[0], a[1], a[2], a[3], t[0], t[1], t[2], t[3]);
      chk(irq_n === ~(e & en), "R9 random irq", irq_n, ~(e & en));
      rd(3'd5, d);
      chk(d === {1'b0, e, 6'b0}, req_of(mk), d, {1'b0, e, 6'b0});
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule